// File: doc/BRIEF.md
# Register Rename Unit

This block translates architectural register numbers into physical register numbers so that an out-of-order core sees no false write-after-read or write-after-write dependences. It keeps 32 architectural registers and 64 physical registers. A register is written here as a zero-based index: architectural index `k` stands for register R(k+1), and physical index `p` stands for register P(p+1).

For each instruction, the rename port reads up to two source mappings from a speculative map. If the instruction writes a register, the port takes the oldest entry of a free pool and installs it as the new mapping. It also returns the mapping that entry replaced, so that the register can be released later.

A commit port applies retired destinations to a committed map and hands the replaced register back to the pool. A flush input discards all speculative state. The speculative map becomes a copy of the committed map, and every register that squashed instructions took goes back to the head of the pool.

The rename port is valid/ready. An instruction is accepted in a cycle where `ren_valid` and `ren_ready` are both high. Its results (`ren_psrc_a`, `ren_psrc_b`, `ren_pdst`, `ren_pold`) are combinational and valid in that same cycle. `ren_ready` does not depend on `ren_valid`. It is low whenever the pool is empty or `flush` is high, and this applies to every instruction, including those without a destination.

The commit port has no back-pressure. The caller must present retired destination writes in the order they were renamed. It must echo back the `ren_pdst` and `ren_pold` values that the block returned for each one.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, ren_ready is high and every architectural index k maps to physical index k in both maps.
- R2: After reset, the pool holds physical indices 32..63 and destinations receive them in ascending order, starting with 32.
- R3: The sources of an accepted instruction are read before its own destination is remapped. If a source equals the destination, that source returns the old mapping, and ren_pold equals that same old mapping.
- R4: Once an instruction with a destination has been accepted, later instructions that read that architectural register receive the newly allocated physical index.
- R5: An accepted instruction with ren_has_dst low consumes no pool entry and leaves the speculative map unchanged.
- R6: When the pool is empty, ren_ready is low and no instruction is accepted.
- R7: A commit with cmt_has_dst high writes cmt_pdst into the committed map and appends cmt_pold at the tail of the pool, so that register is allocated again once the entries ahead of it have been used.
- R8: On flush, the speculative map becomes the committed map, including any commit in the same cycle. Registers taken by uncommitted instructions return to the head of the pool in their original allocation order.
- R9: A commit release and a rename allocation in the same cycle both take effect, and the pool occupancy does not change.
- R10: While flush is high, ren_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request valid |
| ren_ready | output | 1 | Rename can accept this cycle |
| ren_src_a | input | 5 | First source architectural index |
| ren_src_b | input | 5 | Second source architectural index |
| ren_has_dst | input | 1 | Instruction writes a register |
| ren_dst | input | 5 | Destination architectural index |
| ren_psrc_a | output | 6 | Physical index for first source |
| ren_psrc_b | output | 6 | Physical index for second source |
| ren_pdst | output | 6 | Newly allocated physical index |
| ren_pold | output | 6 | Previous mapping of the destination |
| cmt_valid | input | 1 | An instruction retires this cycle |
| cmt_has_dst | input | 1 | Retiring instruction writes a register |
| cmt_dst | input | 5 | Retiring destination architectural index |
| cmt_pdst | input | 6 | Physical index allocated to it at rename |
| cmt_pold | input | 6 | Physical index it replaced, to be released |
| flush | input | 1 | Discard all speculative state |

## Verification
The assertions check the following on every cycle:
- no pop from an empty pool and no push into a full one;
- occupancy is unchanged when a release and an allocation coincide;
- a source that aliases the destination reads the old mapping;
- an instruction without a destination leaves the speculative map untouched;
- ready is low during flush;
- the speculative map equals the committed map in the cycle after a flush.

Only the bench scenarios can show two further properties, because both depend on history that no single cycle exposes. The first is the exact order in which registers come out of the pool: ascending after reset, released registers coming back at the tail, and squashed ones coming back first after a flush. The second is that a stalled pool resumes correctly.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_ARCH_DEF = 32;
  localparam int RN_PHYS_DEF = 64;

  function automatic int rn_ptr_w(input int depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int N  = 32,
  parameter int W  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [W-1:0]   wr_data,
  input  logic           load,
  input  logic [N*W-1:0] load_vec,
  input  logic [IW-1:0]  rd_a_idx,
  input  logic [IW-1:0]  rd_b_idx,
  input  logic [IW-1:0]  rd_c_idx,
  output logic [W-1:0]   rd_a,
  output logic [W-1:0]   rd_b,
  output logic [W-1:0]   rd_c,
  output logic [N*W-1:0] map_vec
);
  logic [W-1:0] mem [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= W'(i);
      else if (load)
        mem[i] <= load_vec[i*W +: W];
      else if (wr_en && (wr_idx == IW'(i)))
        mem[i] <= wr_data;
    end
    assign map_vec[i*W +: W] = mem[i];
  end

  assign rd_a = mem[rd_a_idx];
  assign rd_b = mem[rd_b_idx];
  assign rd_c = mem[rd_c_idx];

  // R4
  map_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load) |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 6,
  parameter int BASE  = 32,
  parameter int PTRW  = rn_pkg::rn_ptr_w(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop,
  input  logic            push,
  input  logic [W-1:0]    push_data,
  input  logic            cmt_adv,
  input  logic            rewind,
  output logic [W-1:0]    head_data,
  output logic            empty,
  output logic [PTRW-1:0] level
);
  localparam int IDXW = PTRW - 1;

  logic [W-1:0]    slot [DEPTH];
  logic [PTRW-1:0] head_q, tail_q, chead_q;
  logic [PTRW-1:0] chead_n;

  assign chead_n = chead_q + PTRW'(cmt_adv);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= W'(BASE + i);
      else if (push && (tail_q[IDXW-1:0] == IDXW'(i)))
        slot[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= PTRW'(DEPTH);
      chead_q <= '0;
    end else begin
      chead_q <= chead_n;
      tail_q  <= tail_q + PTRW'(push);
      if (rewind)
        head_q <= chead_n;
      else
        head_q <= head_q + PTRW'(pop);
    end
  end

  assign level     = tail_q - head_q;
  assign empty     = (level == '0);
  assign head_data = slot[head_q[IDXW-1:0]];

  // R6
  pool_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R7
  pool_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (level < PTRW'(DEPTH)) || pop);
  // R9
  pool_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push && !rewind) |=> (level == $past(level)));
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int NUM_ARCH = rn_pkg::RN_ARCH_DEF,
  parameter int NUM_PHYS = rn_pkg::RN_PHYS_DEF,
  parameter int AW       = $clog2(NUM_ARCH),
  parameter int PW       = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic          ren_has_dst,
  input  logic [AW-1:0] ren_dst,
  output logic [PW-1:0] ren_psrc_a,
  output logic [PW-1:0] ren_psrc_b,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_pold,
  input  logic          cmt_valid,
  input  logic          cmt_has_dst,
  input  logic [AW-1:0] cmt_dst,
  input  logic [PW-1:0] cmt_pdst,
  input  logic [PW-1:0] cmt_pold,
  input  logic          flush
);
  localparam int POOL  = NUM_PHYS - NUM_ARCH;
  localparam int PTRW  = rn_pkg::rn_ptr_w(POOL);
  localparam int VECW  = NUM_ARCH * PW;

  logic            pool_empty;
  logic [PTRW-1:0] pool_level;
  logic            ren_fire, alloc, release_w;
  logic [VECW-1:0] spec_vec, cmt_vec, cmt_vec_n;
  logic [PW-1:0]   cmt_unused_a, cmt_unused_b, cmt_unused_c;

  assign ren_ready = !pool_empty && !flush;
  assign ren_fire  = ren_valid && ren_ready;
  assign alloc     = ren_fire && ren_has_dst;
  assign release_w = cmt_valid && cmt_has_dst;

  rn_free_fifo #(.DEPTH(POOL), .W(PW), .BASE(NUM_ARCH), .PTRW(PTRW)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .pop(alloc), .push(release_w), .push_data(cmt_pold),
    .cmt_adv(release_w), .rewind(flush),
    .head_data(ren_pdst), .empty(pool_empty), .level(pool_level)
  );

  always_comb begin
    cmt_vec_n = cmt_vec;
    if (release_w)
      cmt_vec_n[cmt_dst*PW +: PW] = cmt_pdst;
  end

  rn_map_table #(.N(NUM_ARCH), .W(PW), .IW(AW)) u_spec (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc), .wr_idx(ren_dst), .wr_data(ren_pdst),
    .load(flush), .load_vec(cmt_vec_n),
    .rd_a_idx(ren_src_a), .rd_b_idx(ren_src_b), .rd_c_idx(ren_dst),
    .rd_a(ren_psrc_a), .rd_b(ren_psrc_b), .rd_c(ren_pold),
    .map_vec(spec_vec)
  );

  rn_map_table #(.N(NUM_ARCH), .W(PW), .IW(AW)) u_cmt (
    .clk(clk), .rst_n(rst_n),
    .wr_en(release_w), .wr_idx(cmt_dst), .wr_data(cmt_pdst),
    .load(1'b0), .load_vec('0),
    .rd_a_idx('0), .rd_b_idx('0), .rd_c_idx('0),
    .rd_a(cmt_unused_a), .rd_b(cmt_unused_b), .rd_c(cmt_unused_c),
    .map_vec(cmt_vec)
  );

  // R3
  src_before_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && ren_src_a == ren_dst) |-> (ren_psrc_a == ren_pold));
  // R5
  no_dst_keeps_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_fire && !ren_has_dst) |=> $stable(spec_vec));
  // R8
  flush_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (spec_vec == cmt_vec));
  // R10
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !ren_ready);
endmodule

// File: tb/rn_rename_unit_tb.sv
`timescale 1ns/1ps
module rn_rename_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 0, ren_has_dst = 0, cmt_valid = 0, cmt_has_dst = 0, flush = 0;
  logic [4:0] ren_src_a = 0, ren_src_b = 0, ren_dst = 0, cmt_dst = 0;
  logic [5:0] cmt_pdst = 0, cmt_pold = 0;
  logic ren_ready;
  logic [5:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold;

  always #2 clk = ~clk;

  rn_rename_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_has_dst(ren_has_dst),
    .ren_dst(ren_dst), .ren_psrc_a(ren_psrc_a), .ren_psrc_b(ren_psrc_b),
    .ren_pdst(ren_pdst), .ren_pold(ren_pold), .cmt_valid(cmt_valid),
    .cmt_has_dst(cmt_has_dst), .cmt_dst(cmt_dst), .cmt_pdst(cmt_pdst),
    .cmt_pold(cmt_pold), .flush(flush)
  );

  typedef struct { int d; int p; int o; } inf_t;
  int spec_m [32];
  int cmt_m [32];
  int freeq [$];
  inf_t infq [$];
  int n_tests = 0, n_fail = 0;
  int last_pdst;
  bit saw_reuse;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int got, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic bit exp_ready(input bit fl);
    return (freeq.size() != 0) && !fl;
  endfunction

  task automatic step(input bit v, input int s1, input int s2, input bit hd,
                      input int d, input bit cv, input bit fl, input string tag);
    bit rdy, do_cmt;
    inf_t e;
    int tmp [$];
    @(negedge clk);
    do_cmt = cv && (infq.size() != 0);
    ren_valid = v; ren_src_a = 5'(s1); ren_src_b = 5'(s2);
    ren_has_dst = hd; ren_dst = 5'(d); flush = fl;
    cmt_valid = do_cmt; cmt_has_dst = do_cmt;
    if (do_cmt) begin
      cmt_dst = 5'(infq[0].d); cmt_pdst = 6'(infq[0].p); cmt_pold = 6'(infq[0].o);
    end
    #1;
    rdy = exp_ready(fl);
    check(ren_ready == rdy, tag, "ready", int'(ren_ready), int'(rdy));
    if (v && rdy) begin
      check(ren_psrc_a == 6'(spec_m[s1]), tag, "psrc_a", int'(ren_psrc_a), spec_m[s1]);
      check(ren_psrc_b == 6'(spec_m[s2]), tag, "psrc_b", int'(ren_psrc_b), spec_m[s2]);
      if (hd) begin
        check(ren_pdst == 6'(freeq[0]), tag, "pdst", int'(ren_pdst), freeq[0]);
        check(ren_pold == 6'(spec_m[d]), tag, "pold", int'(ren_pold), spec_m[d]);
        last_pdst = int'(ren_pdst);
      end
    end
    @(posedge clk);
    if (do_cmt) begin
      e = infq.pop_front();
      cmt_m[e.d] = e.p;
      freeq.push_back(e.o);
    end
    if (fl) begin
      foreach (infq[k]) tmp.push_back(infq[k].p);
      foreach (freeq[k]) tmp.push_back(freeq[k]);
      freeq = tmp;
      infq.delete();
      spec_m = cmt_m;
    end else if (v && rdy && hd) begin
      e.d = d; e.p = freeq.pop_front(); e.o = spec_m[d];
      if (e.p < 32) saw_reuse = 1;
      infq.push_back(e);
      spec_m[d] = e.p;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 32; i++) begin spec_m[i] = i; cmt_m[i] = i; freeq.push_back(32 + i); end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset mapping (no-destination lookup)
    step(1, 4, 31, 0, 0, 0, 0, "R1");
    // R2 / R3: R1 <- R1 + R3 reads old R1, receives P33 (index 32)
    step(1, 0, 2, 1, 0, 0, 0, "R3");
    check(last_pdst == 32, "R2", "first alloc", last_pdst, 32);
    // R4: next reader of R1 sees index 32
    step(1, 0, 0, 1, 1, 0, 0, "R4");
    check(last_pdst == 33, "R2", "second alloc", last_pdst, 33);
    // R5: branch without destination
    step(1, 1, 5, 0, 1, 0, 0, "R5");
    // R9: commit and allocate together
    step(1, 1, 0, 1, 2, 1, 0, "R9");
    check(last_pdst == 34, "R9", "alloc with commit", last_pdst, 34);
    // R10: flush blocks rename
    step(1, 0, 0, 1, 3, 0, 1, "R10");
    // R8: restored map, squashed register first
    step(1, 0, 1, 1, 3, 0, 0, "R8");
    check(last_pdst == 33, "R8", "first after flush", last_pdst, 33);
    // R6 / R7: drain pool, released index 0 comes back
    saw_reuse = 0;
    while (freeq.size() != 0)
      step(1, $urandom % 32, $urandom % 32, 1, $urandom % 32, 0, 0, "R7");
    check(saw_reuse, "R7", "released reg reused", int'(saw_reuse), 1);
    step(1, 3, 4, 1, 5, 0, 0, "R6");
    step(1, 3, 4, 0, 5, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, "R8");
    // random phase
    for (int n = 0; n < 4000; n++)
      step(($urandom % 4) != 0, $urandom % 32, $urandom % 32, ($urandom % 5) != 0,
           $urandom % 32, ($urandom % 3) == 0, ($urandom % 60) == 0, "R4");
    // drain with commits then final flush
    for (int n = 0; n < 40; n++) step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, "R8");
    step(1, 7, 8, 0, 0, 0, 0, "R8");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule